// File: doc/BRIEF.md
# 72/64 Cache Line ECC Checker

This block checks the error-correcting code of a cache line as it streams past. A line is four 64-bit data words, and each word arrives together with the 8-bit check byte that was stored beside it. For every accepted beat the block recomputes the eight check bits from the data and XORs them with the stored byte to form a syndrome. It then sorts each nonzero syndrome into a single-bit or a multi-bit class.

Across the four beats of a line the block builds a mask of the words that were bad and keeps two sticky flags, one for single-bit errors and one for multi-bit errors. One cycle after the fourth beat it raises a line-done pulse, and the final mask and flags are valid in that same cycle. Each beat's syndrome and class are also presented, registered, one cycle after the beat is accepted. Correction, writeback and the storage array sit outside this block.

Top module: `ecc72_line_checker`

## Requirements
- R1: Check bit i (0..7) is the XOR of the data bits selected by mask i. Mask 0 is 64'h0738C808099264FF, and mask i is mask 0 rotated left by 8*i bits, so mask 7 is 64'hFF0738C808099264. For data 64'h1 with check byte 0 the syndrome is 8'h23.
- R2: One cycle after a beat is accepted (`beat_valid` high at a rising clock edge), `syn_valid` is high and `syn_out` holds the computed check bits XOR `beat_check`.
- R3: A zero syndrome sets neither `syn_single` nor `syn_multi`. A syndrome with exactly one bit set sets only `syn_single`. Any other nonzero syndrome sets only `syn_multi`.
- R4: Beats in a line take offsets 0, 1, 2 and 3 in arrival order. A beat at offset k with a nonzero syndrome sets bit 3-k of `line_bad_mask`, so offset 0 maps to bit 3 and offset 3 maps to bit 0.
- R5: A beat with `beat_first` high is at offset 0. It clears the mask and both flags before its own result is merged in, including when it arrives in the middle of a line.
- R6: `line_sbe` is set once any beat of the current line has a single-bit class, and `line_dbe` is set once any beat has a multi-bit class. Both stay set until the next line starts.
- R7: `line_done` is high for exactly the one cycle after the beat at offset 3 is accepted. In that cycle `line_bad_mask`, `line_sbe` and `line_dbe` show the result for the whole line.
- R8: A cycle with `beat_valid` low changes no line state. In the following cycle `syn_valid` is low, and the mask and flags are unchanged.
- R9: After reset every output is zero.
- R10: After offset 3, the next accepted beat starts a new line at offset 0 even if `beat_first` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| beat_valid | input | 1 | Beat present this cycle |
| beat_first | input | 1 | Beat is offset 0 of a new line |
| beat_data | input | 64 | Data word |
| beat_check | input | 8 | Stored check byte for the word |
| syn_valid | output | 1 | Syndrome outputs hold a fresh beat result |
| syn_out | output | 8 | Registered syndrome of the last accepted beat |
| syn_single | output | 1 | Last beat had a single-bit syndrome |
| syn_multi | output | 1 | Last beat had a multi-bit syndrome |
| line_done | output | 1 | One-cycle pulse after the fourth beat of a line |
| line_bad_mask | output | 4 | Bad-word mask, offset 0 in bit 3 |
| line_sbe | output | 1 | Sticky single-bit error flag for the line |
| line_dbe | output | 1 | Sticky multi-bit error flag for the line |

## Verification
The beats are built from a clean check byte XORed with chosen flip patterns. A zero flip must give a clean beat. A one-bit flip must land in the single class, and two-bit and all-ones flips must land in the multi class, which shows that the class depends only on the bit count. Corrupting a data bit while keeping the original check byte gives that bit's column of the masks; the constant 8'h23 for bit 0 ties the rotation order down. Directed lines cover idle gaps mid-line, a restart on a mid-line first marker, and a new line that begins without a marker, and each one shows whether the offset counter and the mask bit order are right.

// File: rtl/ecc72_pkg.sv
package ecc72_pkg;

  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int ROT_STEP = 8;
  localparam logic [DATA_W-1:0] BASE_MASK = 64'h0738C808099264FF;

  typedef enum logic [1:0] {
    CLS_CLEAN  = 2'd0,
    CLS_SINGLE = 2'd1,
    CLS_MULTI  = 2'd2
  } err_cls_e;

  // Selection mask for check bit idx: base rotated left by ROT_STEP*idx.
  function automatic logic [DATA_W-1:0] sel_mask(input int idx);
    int sh;
    sh = (ROT_STEP * idx) % DATA_W;
    if (sh == 0) return BASE_MASK;
    return (BASE_MASK << sh) | (BASE_MASK >> (DATA_W - sh));
  endfunction

  function automatic logic [CHK_W-1:0] calc_check(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    for (int i = 0; i < CHK_W; i++) c[i] = ^(d & sel_mask(i));
    return c;
  endfunction

  function automatic err_cls_e classify(input logic [CHK_W-1:0] s);
    if (s == '0) return CLS_CLEAN;
    if ($countones(s) == 1) return CLS_SINGLE;
    return CLS_MULTI;
  endfunction

endpackage

// File: rtl/ecc72_check_gen.sv
module ecc72_check_gen
  import ecc72_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  stored_i,
  output logic [CHK_W-1:0]  syndrome_o
);
  logic [CHK_W-1:0] computed;

  for (genvar gi = 0; gi < CHK_W; gi++) begin : g_bit
    localparam logic [DATA_W-1:0] MASK_I = sel_mask(gi);
    assign computed[gi] = ^(data_i & MASK_I);
  end

  assign syndrome_o = computed ^ stored_i;
endmodule

// File: rtl/ecc72_classify.sv
module ecc72_classify
  import ecc72_pkg::*;
(
  input  logic [CHK_W-1:0] syndrome_i,
  output logic             bad_o,
  output logic             single_o,
  output logic             multi_o
);
  err_cls_e cls;

  always_comb begin
    cls      = classify(syndrome_i);
    bad_o    = (cls != CLS_CLEAN);
    single_o = (cls == CLS_SINGLE);
    multi_o  = (cls == CLS_MULTI);
  end
endmodule

// File: rtl/ecc72_line_acc.sv
module ecc72_line_acc #(
  parameter int BEATS = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic             first_i,
  input  logic             bad_i,
  input  logic             single_i,
  input  logic             multi_i,
  output logic             done_o,
  output logic [BEATS-1:0] mask_o,
  output logic             sbe_o,
  output logic             dbe_o
);
  localparam logic [IDX_W-1:0] LAST_OFF = IDX_W'(BEATS - 1);

  logic [IDX_W-1:0] next_off;
  logic [IDX_W-1:0] cur_off;
  logic             line_start;
  logic             last_beat;
  logic [BEATS-1:0] hit_vec;

  always_comb begin
    cur_off    = first_i ? '0 : next_off;
    line_start = (cur_off == '0);
    last_beat  = (cur_off == LAST_OFF);
    hit_vec    = '0;
    hit_vec[LAST_OFF - cur_off] = bad_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_off <= '0;
      mask_o   <= '0;
      sbe_o    <= 1'b0;
      dbe_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= acc_i && last_beat;
      if (acc_i) begin
        next_off <= last_beat ? '0 : cur_off + 1'b1;
        mask_o   <= (line_start ? '0 : mask_o) | hit_vec;
        sbe_o    <= (line_start ? 1'b0 : sbe_o) | single_i;
        dbe_o    <= (line_start ? 1'b0 : dbe_o) | multi_i;
      end
    end
  end
endmodule

// File: rtl/ecc72_line_checker.sv
module ecc72_line_checker
  import ecc72_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_valid,
  input  logic              beat_first,
  input  logic [63:0]       beat_data,
  input  logic [7:0]        beat_check,
  output logic              syn_valid,
  output logic [7:0]        syn_out,
  output logic              syn_single,
  output logic              syn_multi,
  output logic              line_done,
  output logic [BEATS-1:0]  line_bad_mask,
  output logic              line_sbe,
  output logic              line_dbe
);
  // Named internal events
  logic [CHK_W-1:0] syn_now;
  logic             bad_now;
  logic             single_now;
  logic             multi_now;

  ecc72_check_gen u_gen (
    .data_i     (beat_data),
    .stored_i   (beat_check),
    .syndrome_o (syn_now)
  );

  ecc72_classify u_cls (
    .syndrome_i (syn_now),
    .bad_o      (bad_now),
    .single_o   (single_now),
    .multi_o    (multi_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn_valid  <= 1'b0;
      syn_out    <= '0;
      syn_single <= 1'b0;
      syn_multi  <= 1'b0;
    end else begin
      syn_valid  <= beat_valid;
      syn_single <= beat_valid && single_now;
      syn_multi  <= beat_valid && multi_now;
      if (beat_valid) syn_out <= syn_now;
    end
  end

  ecc72_line_acc #(.BEATS(BEATS)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_i    (beat_valid),
    .first_i  (beat_first),
    .bad_i    (bad_now),
    .single_i (single_now),
    .multi_i  (multi_now),
    .done_o   (line_done),
    .mask_o   (line_bad_mask),
    .sbe_o    (line_sbe),
    .dbe_o    (line_dbe)
  );
endmodule

// File: rtl/ecc72_line_checker_sva.sv
module ecc72_line_checker_sva #(
  parameter int BEATS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             beat_valid,
  input logic             beat_first,
  input logic             syn_valid,
  input logic [7:0]       syn_out,
  input logic             syn_single,
  input logic             syn_multi,
  input logic             line_done,
  input logic [BEATS-1:0] line_bad_mask,
  input logic             line_sbe,
  input logic             line_dbe
);
  AST_SYN_FOLLOWS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |=> syn_valid); // R2

  AST_SINGLE_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    syn_single |-> ($countones(syn_out) == 1 && !syn_multi)); // R3

  AST_MULTI_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    syn_multi |-> ($countones(syn_out) > 1)); // R3

  AST_SBE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    syn_single |-> line_sbe); // R6

  AST_DBE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    syn_multi |-> line_dbe); // R6

  AST_FIRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_first) |=> ($countones(line_bad_mask) <= 1)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |=> (!syn_valid && $stable(line_bad_mask) && $stable(line_sbe)
                     && $stable(line_dbe) && !line_done)); // R8
endmodule

bind ecc72_line_checker ecc72_line_checker_sva #(.BEATS(BEATS)) u_sva (.*);

// File: tb/ecc72_line_checker_tb.sv
module ecc72_line_checker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        beat_valid = 1'b0;
  logic        beat_first = 1'b0;
  logic [63:0] beat_data = '0;
  logic [7:0]  beat_check = '0;
  logic        syn_valid, syn_single, syn_multi, line_done, line_sbe, line_dbe;
  logic [7:0]  syn_out;
  logic [3:0]  line_bad_mask;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ecc72_line_checker u_dut (.*);

  // Reference check bits: bit-rotation built here with concatenation.
  function automatic logic [7:0] ref_check(input logic [63:0] d);
    logic [63:0] m;
    logic [7:0]  c;
    m = 64'h0738C808099264FF;
    for (int i = 0; i < 8; i++) begin
      c[i] = ^(d & m);
      m = {m[55:0], m[63:56]};
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one beat, then sample one cycle later at the falling edge.
  task automatic beat(input logic first, input logic [63:0] d, input logic [7:0] c);
    @(negedge clk);
    beat_valid = 1'b1; beat_first = first; beat_data = d; beat_check = c;
    @(negedge clk);
    beat_valid = 1'b0; beat_first = 1'b0;
  endtask

  task automatic check_beat(input logic [7:0] s);
    chk("R2 syn_valid", syn_valid, 1);
    chk("R2 syndrome", syn_out, s);
    chk("R3 single", syn_single, $countones(s) == 1);
    chk("R3 multi", syn_multi, $countones(s) > 1);
  endtask

  localparam int NV = 8;
  localparam logic [63:0] TV_DATA [NV] = '{
    64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF, 64'h0123456789ABCDEF, 64'hDEADBEEFCAFEF00D,
    64'h8000000000000001, 64'h5555AAAA5555AAAA, 64'h0F0F0F0F0F0F0F0F, 64'h1000000000000000};
  localparam logic [7:0] TV_FLIP [NV] = '{
    8'h00, 8'h10, 8'h00, 8'h81,
    8'h00, 8'h00, 8'hFF, 8'h02};

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] exp_mask;
    logic       exp_s, exp_d;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset outputs",
        {syn_valid, syn_out, syn_single, syn_multi, line_done, line_bad_mask, line_sbe, line_dbe}, 0);
    rst_n = 1'b1;

    // R1: fixed column for data bit 0
    beat(1'b1, 64'h1, 8'h00);
    chk("R1 column of bit 0", syn_out, 8'h23);
    chk("R1 mask7 column of bit 63", ref_check(64'h8000000000000000)[7], 1'b1);

    // Table: two lines of four beats
    for (int ln = 0; ln < NV / 4; ln++) begin
      exp_mask = '0; exp_s = 0; exp_d = 0;
      for (int k = 0; k < 4; k++) begin
        int v = ln * 4 + k;
        beat(k == 0, TV_DATA[v], ref_check(TV_DATA[v]) ^ TV_FLIP[v]);
        check_beat(TV_FLIP[v]);
        if (TV_FLIP[v] != 0) exp_mask[3 - k] = 1'b1;
        if ($countones(TV_FLIP[v]) == 1) exp_s = 1'b1;
        if ($countones(TV_FLIP[v]) > 1) exp_d = 1'b1;
        chk("R7 line_done timing", line_done, k == 3);
      end
      chk("R4 line mask", line_bad_mask, exp_mask);
      chk("R6 sbe", line_sbe, exp_s);
      chk("R6 dbe", line_dbe, exp_d);
    end

    // R1/R3: corrupt a data bit with the clean check byte
    beat(1'b1, 64'h0000000100000000, ref_check(64'h0));
    check_beat(ref_check(64'h0000000100000000));

    // R8: idle gap mid-line holds state
    beat(1'b0, 64'h0, 8'h01);          // offset 1, single
    @(negedge clk); @(negedge clk);
    chk("R8 no syn_valid when idle", syn_valid, 0);
    chk("R8 mask held", line_bad_mask, 4'b0100 | (($countones(ref_check(64'h0000000100000000)) != 0) ? 4'b1000 : 4'b0000));
    chk("R8 sbe held", line_sbe, 1);
    beat(1'b0, 64'h0, 8'h00);
    beat(1'b0, 64'h0, 8'h03);
    chk("R7 done after idle gaps", line_done, 1);
    chk("R4 offset 3 at bit 0", line_bad_mask[0], 1);

    // R10: next beat without marker starts a new line at offset 0
    beat(1'b0, 64'h0, 8'h40);
    chk("R10 new line offset 0", line_bad_mask, 4'b1000);
    chk("R10 flags reset", {line_sbe, line_dbe}, 2'b10);

    // R5: mid-line first marker restarts accumulation
    beat(1'b0, 64'h0, 8'hC0);          // offset 1, multi
    chk("R5 pre-restart mask", line_bad_mask, 4'b1100);
    beat(1'b1, 64'h0, 8'h00);          // restart, clean
    chk("R5 restart clears mask", line_bad_mask, 4'b0000);
    chk("R5 restart clears flags", {line_sbe, line_dbe}, 2'b00);
    beat(1'b0, 64'h0, 8'h00);
    beat(1'b0, 64'h0, 8'h00);
    chk("R5 no early done", line_done, 0);
    beat(1'b0, 64'h0, 8'h08);
    chk("R5 done after four beats", line_done, 1);
    chk("R4 restart mask", line_bad_mask, 4'b0001);
    @(negedge clk);
    chk("R7 done single cycle", line_done, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule